// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block decides where instruction fetch goes next in a 32-bit load/store processor whose instructions are all one 32-bit word. Each cycle it takes the address of the current instruction, the instruction word itself, and the two source operand values that a register file has already read for that instruction. It classifies the word as sequential, a conditional branch, an absolute jump inside the current 256 MiB region, a jump that also saves a return address, or a jump through a register. From that class it produces the following fetch address and, for the saving jump, a request to write the return address into the link register.

Only control-flow opcodes are decoded. Every other word, including register-type words with other function codes, moves straight on to the next word. All results are registered, so the values computed from the inputs present before a rising clock edge appear on the outputs just after that edge. The bench and the requirements below rely on this one-cycle latency.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `next_pc_o` equals the parameter `RESET_PC` (default 0), and `link_we_o`, `link_idx_o`, `link_val_o` and `misalign_o` are all zero.
- R2: An instruction whose opcode (bits 31:26) is none of 0x02, 0x03, 0x04, 0x05, and is not opcode 0x00 with function code (bits 5:0) 0x08, gives `next_pc_o` = PC + 4 one cycle later, with no link write and no alignment flag.
- R3: Opcode 0x04 (branch when equal) with equal operands gives `next_pc_o` = PC + 4 + (sign-extended bits 15:0 shifted left by 2); with unequal operands it gives PC + 4.
- R4: Opcode 0x05 (branch when not equal) takes the same target when the operands differ, and gives PC + 4 when they are equal.
- R5: Opcode 0x02 (jump) gives `next_pc_o` = {bits 31:28 of PC + 4, bits 25:0 of the instruction, 2'b00}.
- R6: Opcode 0x03 (jump and link) jumps as in R5 and, in the same output cycle, drives `link_we_o` = 1, `link_idx_o` = 31 and `link_val_o` = PC + 4.
- R7: Opcode 0x00 with function code 0x08 (register jump) gives `next_pc_o` equal to the `rs_val_i` value unchanged; `misalign_o` is 1 exactly when bits 1:0 of that value are not both zero.
- R8: For every instruction other than jump and link, `link_we_o`, `link_idx_o` and `link_val_o` are zero, so a link write lasts one cycle for each jump-and-link word presented.
- R9: The branch offset spans -32768 to +32767 words and the sum wraps modulo 2^32.
- R10: The region bits for R5 and R6 come from PC + 4, not PC, so a jump in the last word of a region lands in the following region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Registered address of the next instruction to fetch |
| link_we_o | output | 1 | Registered link-register write request |
| link_idx_o | output | 5 | Registered index of the register to write (31 when writing) |
| link_val_o | output | 32 | Registered return address to write |
| misalign_o | output | 1 | Registered flag: register-jump target not word aligned |

## Verification
The hardest cases to reach are the edges of the address arithmetic. These are the most negative and most positive branch offsets wrapping around the 32-bit space, and a jump placed in the last word of a 256 MiB region, where PC and PC + 4 differ in their top four bits. Random PCs almost never land there. The stimulus therefore sets these PCs and offsets directly, then adds a long random run over all opcode classes in which equal and unequal operand pairs are forced about equally often. A behavioural model in the bench predicts every output one cycle ahead.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int REG_W     = 5;
    localparam int IMM_W     = 16;
    localparam int JT_W      = 26;
    localparam int WORD_SH   = 2;
    localparam int REGION_W  = XLEN - JT_W - WORD_SH;

    localparam logic [OP_W-1:0]  OPC_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0]  OPC_JUMP    = 6'h02;
    localparam logic [OP_W-1:0]  OPC_JLINK   = 6'h03;
    localparam logic [OP_W-1:0]  OPC_BREQ    = 6'h04;
    localparam logic [OP_W-1:0]  OPC_BRNE    = 6'h05;
    localparam logic [FN_W-1:0]  FN_REGJUMP  = 6'h08;
    localparam logic [REG_W-1:0] RA_INDEX    = 5'd31;
    localparam logic [XLEN-1:0]  STEP_BYTES  = 32'd4;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        flow_e             kind;
        logic [IMM_W-1:0]  off;
        logic [JT_W-1:0]   jt;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] br;
        logic [XLEN-1:0] jmp;
    } targets_t;

    typedef struct packed {
        logic [XLEN-1:0]  npc;
        logic             lwe;
        logic [REG_W-1:0] lidx;
        logic [XLEN-1:0]  lval;
        logic             mis;
    } flow_out_t;

    function automatic logic [XLEN-1:0] word_off(input logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return ext << WORD_SH;
    endfunction

    function automatic logic [XLEN-1:0] region_join(input logic [XLEN-1:0] base,
                                                    input logic [JT_W-1:0] jt);
        return {base[XLEN-1 -: REGION_W], jt, {WORD_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;

    assign opc = instr[XLEN-1 -: OP_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        dec.off = instr[IMM_W-1:0];
        dec.jt  = instr[JT_W-1:0];
        unique case (opc)
            OPC_JUMP:    dec.kind = FLOW_JMP;
            OPC_JLINK:   dec.kind = FLOW_JAL;
            OPC_BREQ:    dec.kind = FLOW_BEQ;
            OPC_BRNE:    dec.kind = FLOW_BNE;
            OPC_SPECIAL: dec.kind = (fn == FN_REGJUMP) ? FLOW_JREG : FLOW_SEQ;
            default:     dec.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  dec_t            dec,
    output targets_t        tgt
);
    logic [XLEN-1:0] pc_next;

    assign pc_next  = pc + STEP_BYTES;
    assign tgt.seq  = pc_next;
    assign tgt.br   = pc_next + word_off(dec.off);
    assign tgt.jmp  = region_join(pc_next, dec.jt);
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  dec_t            dec,
    input  targets_t        tgt,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    output flow_out_t       res
);
    logic same;

    assign same = (a_val == b_val);

    always_comb begin
        res.npc  = tgt.seq;
        res.lwe  = 1'b0;
        res.lidx = '0;
        res.lval = '0;
        res.mis  = 1'b0;
        unique case (dec.kind)
            FLOW_BEQ:  if (same)  res.npc = tgt.br;
            FLOW_BNE:  if (!same) res.npc = tgt.br;
            FLOW_JMP:  res.npc = tgt.jmp;
            FLOW_JAL: begin
                res.npc  = tgt.jmp;
                res.lwe  = 1'b1;
                res.lidx = RA_INDEX;
                res.lval = tgt.seq;
            end
            FLOW_JREG: begin
                res.npc = a_val;
                res.mis = |a_val[WORD_SH-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pc_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] next_pc_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_val_o,
    output logic        misalign_o
);
    dec_t      dec;
    targets_t  tgt;
    flow_out_t res;
    flow_out_t res_q;

    npc_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    npc_targets u_tgt (
        .pc  (pc_i),
        .dec (dec),
        .tgt (tgt)
    );

    npc_select u_sel (
        .dec   (dec),
        .tgt   (tgt),
        .a_val (rs_val_i),
        .b_val (rt_val_i),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q.npc  <= RESET_PC;
            res_q.lwe  <= 1'b0;
            res_q.lidx <= '0;
            res_q.lval <= '0;
            res_q.mis  <= 1'b0;
        end else begin
            res_q <= res;
        end
    end

    assign next_pc_o  = res_q.npc;
    assign link_we_o  = res_q.lwe;
    assign link_idx_o = res_q.lidx;
    assign link_val_o = res_q.lval;
    assign misalign_o = res_q.mis;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_i,
    input logic [31:0] instr_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] next_pc_o,
    input logic        link_we_o,
    input logic [4:0]  link_idx_o,
    input logic [31:0] link_val_o,
    input logic        misalign_o
);
    logic [5:0] op_now;
    logic       is_jreg, is_jal, is_jmp, is_ctl;

    assign op_now  = instr_i[31:26];
    assign is_jreg = (op_now == 6'h00) && (instr_i[5:0] == 6'h08);
    assign is_jal  = (op_now == 6'h03);
    assign is_jmp  = (op_now == 6'h02) || is_jal;
    assign is_ctl  = is_jmp || is_jreg || (op_now == 6'h04) || (op_now == 6'h05);

    // R2: plain words step by one word
    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(is_ctl)) |-> (next_pc_o == $past(pc_i) + 32'd4));

    // R6: link write carries return address and register 31
    a_r6_link_fields: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o == $past(pc_i) + 32'd4 && link_idx_o == 5'd31));

    // R8: no link write unless the previous word was jump and link
    a_r8_link_only_jal: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(is_jal)) |-> (!link_we_o && link_idx_o == 5'd0));

    // R7: register jump passes the operand through and flags low bits
    a_r7_reg_target: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_jreg)) |->
            (next_pc_o == $past(rs_val_i) && misalign_o == ($past(rs_val_i[1:0]) != 2'b00)));

    // R7: alignment flag only follows a register jump
    a_r7_flag_source: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> $past(is_jreg));

    // R5: region jumps land word aligned in the region of PC+4
    a_r5_region: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_jmp)) |->
            (next_pc_o[1:0] == 2'b00 && next_pc_o[31:28] == (($past(pc_i) + 32'd4) >> 28)));
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic        link_we_o, misalign_o;
    logic [4:0]  link_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic [31:0] npc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] lval;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_val_o(link_val_o), .misalign_o(misalign_o)
    );

    function automatic exp_t model(input logic [31:0] pc, input logic [31:0] ins,
                                   input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        longint off;
        int op, fn;
        op = int'(ins[31:26]);
        fn = int'(ins[5:0]);
        off = longint'($signed(ins[15:0])) * 4;
        e.npc = pc + 32'd4; e.we = 0; e.idx = 0; e.lval = 0; e.mis = 0; e.tag = "R2";
        if (op == 4 || op == 5) begin
            e.tag = (op == 4) ? "R3" : "R4";
            if ((op == 4) == (a == b)) e.npc = 32'(longint'(pc) + 4 + off);
        end else if (op == 2 || op == 3) begin
            e.tag = (op == 2) ? "R5" : "R6";
            e.npc = ((pc + 32'd4) & 32'hF000_0000) | (32'(ins[25:0]) * 4);
            if (op == 3) begin
                e.we = 1; e.idx = 31; e.lval = pc + 32'd4;
            end
        end else if (op == 0 && fn == 8) begin
            e.tag = "R7";
            e.npc = a;
            e.mis = (a % 4) != 0;
        end
        return e;
    endfunction

    task automatic compare(input exp_t e);
        n_checks++;
        if (next_pc_o !== e.npc || link_we_o !== e.we || link_idx_o !== e.idx ||
            link_val_o !== e.lval || misalign_o !== e.mis) begin
            n_fail++;
            $display("FAIL %s actual npc=%h we=%b idx=%0d lval=%h mis=%b expected npc=%h we=%b idx=%0d lval=%h mis=%b",
                     e.tag, next_pc_o, link_we_o, link_idx_o, link_val_o, misalign_o,
                     e.npc, e.we, e.idx, e.lval, e.mis);
        end
    endtask

    // called after a negedge: check what the previous vector produced, then drive the next
    task automatic step(input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
        e = model(pc, ins, a, b);
        if (tag != "") e.tag = tag;
        q.push_back(e);
    endtask

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd1, 5'd2, imm};
    endfunction

    function automatic logic [31:0] jtype(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        // R1: reset state
        r.npc = 32'h0; r.we = 0; r.idx = 0; r.lval = 0; r.mis = 0; r.tag = "R1";
        compare(r);
        rst = 1'b0;
        q.delete();
        // R2: non-control words
        step(32'h0000_0100, 32'h012A_4020, 0, 0, "R2");
        step(32'h0000_0104, 32'h8C22_0010, 5, 5, "R2");
        step(32'h0000_0108, 32'h0220_0009, 32'h40, 0, "R2");
        step(32'hFFFF_FFFC, 32'hAC22_0000, 0, 0, "R2");
        // R3 / R4
        step(32'h0000_0100, itype(6'h04, 16'd3), 7, 7, "R3");
        step(32'h0000_0100, itype(6'h04, 16'd3), 7, 8, "R3");
        step(32'h0000_0200, itype(6'h05, 16'hFFFE), 1, 2, "R4");
        step(32'h0000_0200, itype(6'h05, 16'hFFFE), 9, 9, "R4");
        // R9: offset extremes and wrap
        step(32'h0000_1000, itype(6'h04, 16'h7FFF), 0, 0, "R9");
        step(32'h0000_1000, itype(6'h04, 16'h8000), 0, 0, "R9");
        step(32'hFFFF_FFF8, itype(6'h05, 16'h0002), 1, 0, "R9");
        // R5 / R10
        step(32'h4000_0000, jtype(6'h02, 26'h10), 0, 0, "R5");
        step(32'h0FFF_FFFC, jtype(6'h02, 26'h3FF_FFFF), 0, 0, "R10");
        step(32'h0FFF_FFFC, jtype(6'h03, 26'h000_0001), 0, 0, "R10");
        // R6 / R8
        step(32'h0040_0000, jtype(6'h03, 26'h010_0040), 0, 0, "R6");
        step(32'h0040_0100, 32'h012A_4020, 0, 0, "R8");
        step(32'h0040_0104, jtype(6'h02, 26'h5), 0, 0, "R8");
        // R7
        step(32'h0000_0300, {6'h00, 5'd31, 15'd0, 6'h08}, 32'h0000_1234, 0, "R7");
        step(32'h0000_0300, {6'h00, 5'd31, 15'd0, 6'h08}, 32'h0000_1236, 0, "R7");
        step(32'h0000_0300, {6'h00, 5'd31, 15'd0, 6'h08}, 32'hFFFF_FFFD, 0, "R7");
        // random mix across all classes
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins, a, b, pc;
            int pick;
            pick = int'($urandom_range(0, 6));
            ins  = $urandom;
            case (pick)
                0: ins[31:26] = 6'h02;
                1: ins[31:26] = 6'h03;
                2: ins[31:26] = 6'h04;
                3: ins[31:26] = 6'h05;
                4: begin ins[31:26] = 6'h00; ins[5:0] = 6'h08; end
                5: ins[31:26] = 6'h00;
                default: ;
            endcase
            pc = $urandom & 32'hFFFF_FFFC;
            a  = $urandom;
            b  = ($urandom_range(0, 1) == 1) ? a : $urandom;
            step(pc, ins, a, b, "");
        end
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule